// File: doc/BRIEF.md
# Display Register Command-Stream Executor

This block runs a program of fixed-size 64-bit instructions held in a local command memory and turns it into write transactions on a display register bus. Software programs a start pointer and an end pointer, both byte addresses, and pulses a start strobe. The engine then fetches and executes instructions in order until its fetch address equals the end pointer. It only writes registers. It supports single writes with byte enables and burst writes of many dwords to one register offset. Timing waits and register polls are passed to external wait and poll units through a start/done handshake, and the engine stalls until the unit reports done.

The engine also supports a single level of subroutine call. A call instruction names the start and end of a code segment in 64-byte units. The engine runs that segment and then resumes at the instruction after the call. A call made from inside a subroutine is rejected. An interrupt instruction sets a sticky status flag. Two further sticky flags record a rejected nested call and an unrecognised opcode. All three flags are cleared by writing 1.

Top module: `cmd_stream_exec`

## Requirements
- R1: After reset, busy_o, reg_wr_o, irq_o, err_nest_o and err_op_o are all 0.
- R2: A start_i pulse while idle loads head_i and tail_i. Bits 5:0 of each are ignored, so both are 64-byte aligned. busy_o is 1 from the cycle after start until the fetch address equals the tail and no subroutine is active. With head equal to tail, busy_o is high for exactly one cycle.
- R3: Instruction layout: the lower word sits at the even dword address and the upper word at the next one, and bits 31:24 of the upper word are the opcode. Opcode 0x00 is a no-op and produces no register write.
- R4: Opcode 0x01 produces one write. The offset is upper[19:0], the byte enables are upper[23:20] (bit 3 covers data bits 31:24), and the data is the lower word.
- R5: Opcode 0x09 writes the next N dwords, where N is the lower word, all to offset upper[19:0] with byte enables 0xF. When N is odd, the following pad word is skipped unread. N equal to 0 writes nothing. Every following instruction starts on an even dword.
- R6: Opcodes 0x02 to 0x06 pulse wait_start_o, and opcode 0x0A pulses poll_start_o. With the pulse, aux_op_o carries the opcode, aux_hi_o carries upper[23:0] and aux_lo_o carries the lower word. No further instruction runs until the matching done input is seen.
- R7: Opcode 0x07 sets irq_o. irq_o stays set until clr_i[0] is written with 1.
- R8: Opcode 0x0C is a call. The 52-bit payload {upper[19:0], lower} holds the end pointer in bits 25:0 and the start pointer in bits 51:26, each a byte address shifted right by 6. The segment runs, and when its end is reached execution resumes at the instruction after the call.
- R9: A call issued inside a subroutine is not executed. It sets err_nest_o, which is cleared by clr_i[1], and execution continues with the next instruction.
- R10: Any other opcode sets err_op_o, which is cleared by clr_i[2]. Execution stops, busy_o drops on the next cycle, and no later instruction is executed.
- R11: When halt_i is high at an instruction boundary, the engine stops without fetching further, and busy_o drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| head_i | input | AW+2 | Program start byte address |
| tail_i | input | AW+2 | Program end byte address |
| halt_i | input | 1 | Stop at next instruction boundary |
| busy_o | output | 1 | Engine executing |
| mem_rd_o | output | 1 | Command memory read strobe |
| mem_addr_o | output | AW | Command memory dword address |
| mem_rdata_i | input | 32 | Read data, one cycle after the strobe |
| reg_wr_o | output | 1 | Register write strobe |
| reg_addr_o | output | 20 | Register offset |
| reg_be_o | output | 4 | Byte enables |
| reg_data_o | output | 32 | Write data |
| wait_start_o | output | 1 | Start of a wait operation |
| poll_start_o | output | 1 | Start of a poll operation |
| aux_op_o | output | 8 | Opcode of the wait or poll |
| aux_hi_o | output | 24 | Upper word operand bits |
| aux_lo_o | output | 32 | Lower word operand |
| wait_done_i | input | 1 | Wait unit finished |
| poll_done_i | input | 1 | Poll unit finished |
| irq_o | output | 1 | Sticky program interrupt |
| err_nest_o | output | 1 | Sticky nested call error |
| err_op_o | output | 1 | Sticky unknown opcode error |
| clr_i | input | 3 | Write-1-to-clear for {err_op, err_nest, irq} |

## Verification
The properties assume that command memory returns data exactly one cycle after a read strobe. They also assume that a done input is raised only after the matching start pulse, and that the programs they see have tails reachable on even dwords. The bench memory model is a synchronous array, so read latency is fixed. Its wait and poll responder raises done for a single cycle only, a fixed delay after each start pulse. Every program it loads places pointers on 64-byte boundaries and pads unused space with zero words, which are no-ops.

// File: rtl/cmd_pkg.sv
package cmd_pkg;
  localparam logic [7:0] OP_NOP  = 8'h00;
  localparam logic [7:0] OP_WR   = 8'h01;
  localparam logic [7:0] OP_IRQ  = 8'h07;
  localparam logic [7:0] OP_IDX  = 8'h09;
  localparam logic [7:0] OP_POLL = 8'h0A;
  localparam logic [7:0] OP_CALL = 8'h0C;

  typedef enum logic [3:0] {
    S_IDLE, S_CHK, S_RD_LO, S_RD_HI, S_EXEC, S_AUX_GO, S_AUX_WAIT, S_IDX_A, S_IDX_D
  } state_e;

  function automatic logic is_wait(input logic [7:0] op);
    return (op >= 8'h02) && (op <= 8'h06);
  endfunction

  function automatic logic is_known(input logic [7:0] op);
    return (op <= 8'h07) || (op == OP_IDX) || (op == OP_POLL) || (op == OP_CALL);
  endfunction
endpackage

// File: rtl/cmd_status.sv
module cmd_status #(
  parameter int NB = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NB-1:0] set_i,
  input  logic [NB-1:0] clr_i,
  output logic [NB-1:0] flag_o
);
  for (genvar g = 0; g < NB; g++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          flag_q <= 1'b0;
      else if (set_i[g])    flag_q <= 1'b1;
      else if (clr_i[g])    flag_q <= 1'b0;
    end
    assign flag_o[g] = flag_q;

    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q && !clr_i[g]) |=> flag_q); // R7
  end
endmodule

// File: rtl/cmd_link.sv
module cmd_link #(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic [AW-1:0] ret_pc_i,
  input  logic [AW-1:0] main_end_i,
  output logic          in_sub_o,
  output logic [AW-1:0] ret_pc_o,
  output logic [AW-1:0] main_end_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_sub_o   <= 1'b0;
      ret_pc_o   <= '0;
      main_end_o <= '0;
    end else if (call_i) begin
      in_sub_o   <= 1'b1;
      ret_pc_o   <= ret_pc_i;
      main_end_o <= main_end_i;
    end else if (ret_i) begin
      in_sub_o   <= 1'b0;
    end
  end

  AST_NO_NESTED_CALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_i |-> !in_sub_o); // R9
  AST_RET_IN_SUB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_i |-> in_sub_o); // R8
endmodule

// File: rtl/cmd_stream_exec.sv
module cmd_stream_exec
  import cmd_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW+1:0] head_i,
  input  logic [AW+1:0] tail_i,
  input  logic          halt_i,
  output logic          busy_o,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [31:0]   mem_rdata_i,
  output logic          reg_wr_o,
  output logic [19:0]   reg_addr_o,
  output logic [3:0]    reg_be_o,
  output logic [31:0]   reg_data_o,
  output logic          wait_start_o,
  output logic          poll_start_o,
  output logic [7:0]    aux_op_o,
  output logic [23:0]   aux_hi_o,
  output logic [31:0]   aux_lo_o,
  input  logic          wait_done_i,
  input  logic          poll_done_i,
  output logic          irq_o,
  output logic          err_nest_o,
  output logic          err_op_o,
  input  logic [2:0]    clr_i
);
  localparam int PTR_W = AW - 4;  // 64-byte units within the memory

  state_e        state_q;
  logic [AW-1:0] pc_q, end_q;
  logic [31:0]   lo_q, hi_q, cnt_q;
  logic [19:0]   idx_off_q;

  logic [7:0]    op;
  logic          in_exec, bad_op, do_call, nest_err, do_ret, aux_done;
  logic          in_sub;
  logic [AW-1:0] ret_pc, main_end, call_head, call_tail, pc_next;
  logic [25:0]   head_ptr, tail_ptr;
  logic [2:0]    st_set, st_flag;
  logic          unused_bits;

  assign op        = mem_rdata_i[31:24];
  assign in_exec   = (state_q == S_EXEC);
  assign bad_op    = in_exec && !is_known(op);
  assign do_call   = in_exec && (op == OP_CALL) && !in_sub;
  assign nest_err  = in_exec && (op == OP_CALL) && in_sub;
  assign do_ret    = (state_q == S_CHK) && !halt_i && (pc_q == end_q) && in_sub;
  assign aux_done  = (hi_q[31:24] == OP_POLL) ? poll_done_i : wait_done_i;
  assign pc_next   = pc_q + AW'(2);

  assign head_ptr  = {mem_rdata_i[19:0], lo_q[31:26]};
  assign tail_ptr  = lo_q[25:0];
  assign call_head = {head_ptr[PTR_W-1:0], 4'b0000};
  assign call_tail = {tail_ptr[PTR_W-1:0], 4'b0000};
  assign unused_bits = ^{head_i[5:0], tail_i[5:0], head_ptr[25:PTR_W], tail_ptr[25:PTR_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      pc_q      <= '0;
      end_q     <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
      cnt_q     <= '0;
      idx_off_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          pc_q    <= {head_i[AW+1:6], 4'b0000};
          end_q   <= {tail_i[AW+1:6], 4'b0000};
          state_q <= S_CHK;
        end
        S_CHK: begin
          if (halt_i)              state_q <= S_IDLE;
          else if (pc_q == end_q) begin
            if (in_sub) begin
              pc_q  <= ret_pc;
              end_q <= main_end;
            end else state_q <= S_IDLE;
          end else state_q <= S_RD_LO;
        end
        S_RD_LO: state_q <= S_RD_HI;
        S_RD_HI: begin
          lo_q    <= mem_rdata_i;
          state_q <= S_EXEC;
        end
        S_EXEC: begin
          hi_q <= mem_rdata_i;
          if (!is_known(op)) begin
            state_q <= S_IDLE;
          end else if (is_wait(op) || op == OP_POLL) begin
            state_q <= S_AUX_GO;
          end else if (op == OP_IDX) begin
            pc_q      <= pc_next;
            cnt_q     <= lo_q;
            idx_off_q <= mem_rdata_i[19:0];
            state_q   <= (lo_q == '0) ? S_CHK : S_IDX_A;
          end else if (do_call) begin
            pc_q    <= call_head;
            end_q   <= call_tail;
            state_q <= S_CHK;
          end else begin
            pc_q    <= pc_next;
            state_q <= S_CHK;
          end
        end
        S_AUX_GO: state_q <= S_AUX_WAIT;
        S_AUX_WAIT: if (aux_done) begin
          pc_q    <= pc_next;
          state_q <= S_CHK;
        end
        S_IDX_A: state_q <= S_IDX_D;
        S_IDX_D: begin
          cnt_q <= cnt_q - 32'd1;
          if (cnt_q == 32'd1) begin
            // skip pad word so the next instruction is even-aligned
            pc_q    <= pc_q[0] ? pc_q + AW'(1) : pc_next;
            state_q <= S_CHK;
          end else begin
            pc_q    <= pc_q + AW'(1);
            state_q <= S_IDX_A;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != S_IDLE);
  assign mem_rd_o   = (state_q == S_RD_LO) || (state_q == S_RD_HI) || (state_q == S_IDX_A);
  assign mem_addr_o = (state_q == S_RD_HI) ? pc_q + AW'(1) : pc_q;

  assign reg_wr_o   = (in_exec && op == OP_WR) || (state_q == S_IDX_D);
  assign reg_addr_o = (state_q == S_IDX_D) ? idx_off_q : mem_rdata_i[19:0];
  assign reg_be_o   = (state_q == S_IDX_D) ? 4'hF : mem_rdata_i[23:20];
  assign reg_data_o = (state_q == S_IDX_D) ? mem_rdata_i : lo_q;

  assign wait_start_o = (state_q == S_AUX_GO) && is_wait(hi_q[31:24]);
  assign poll_start_o = (state_q == S_AUX_GO) && (hi_q[31:24] == OP_POLL);
  assign aux_op_o     = hi_q[31:24];
  assign aux_hi_o     = hi_q[23:0];
  assign aux_lo_o     = lo_q;

  assign st_set = {bad_op, nest_err, in_exec && (op == OP_IRQ)};

  cmd_link #(.AW(AW)) link_i (
    .clk_i, .rst_ni,
    .call_i     (do_call),
    .ret_i      (do_ret),
    .ret_pc_i   (pc_next),
    .main_end_i (end_q),
    .in_sub_o   (in_sub),
    .ret_pc_o   (ret_pc),
    .main_end_o (main_end)
  );

  cmd_status #(.NB(3)) status_i (
    .clk_i, .rst_ni,
    .set_i  (st_set),
    .clr_i  (clr_i),
    .flag_o (st_flag)
  );

  assign irq_o      = st_flag[0];
  assign err_nest_o = st_flag[1];
  assign err_op_o   = st_flag[2];

  AST_BAD_OP_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_op |=> (!busy_o && err_op_o)); // R10
  AST_EVEN_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CHK) |-> !pc_q[0]); // R5
  AST_AUX_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_AUX_WAIT && !aux_done) |=> (!reg_wr_o && !mem_rd_o)); // R6
  AST_HALT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CHK && halt_i) |=> !busy_o); // R11
  AST_TAIL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CHK && !halt_i && pc_q == end_q && !in_sub) |=> !busy_o); // R2
endmodule

// File: tb/cmd_stream_exec_tb_top.sv
module cmd_stream_exec_tb_top;
  localparam int AW = 10;
  localparam int CLK_PERIOD = 10;
  localparam int AUX_LAT = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, halt_i = 1'b0;
  logic [AW+1:0] head_i = '0, tail_i = '0;
  logic busy_o, mem_rd_o, reg_wr_o, wait_start_o, poll_start_o;
  logic [AW-1:0] mem_addr_o;
  logic [31:0] mem_rdata_i = '0, reg_data_o, aux_lo_o;
  logic [19:0] reg_addr_o;
  logic [3:0] reg_be_o;
  logic [7:0] aux_op_o;
  logic [23:0] aux_hi_o;
  logic wait_done_i, poll_done_i;
  logic irq_o, err_nest_o, err_op_o;
  logic [2:0] clr_i = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cmd_stream_exec #(.AW(AW)) dut_i (.*);

  logic [31:0] mem [0:(1<<AW)-1];
  always @(posedge clk_i) if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  int wl_n = 0;
  logic [19:0] wl_addr [0:31];
  logic [3:0]  wl_be   [0:31];
  logic [31:0] wl_data [0:31];
  int          wl_cyc  [0:31];
  always @(negedge clk_i) if (reg_wr_o && wl_n < 32) begin
    wl_addr[wl_n] = reg_addr_o; wl_be[wl_n] = reg_be_o;
    wl_data[wl_n] = reg_data_o; wl_cyc[wl_n] = cyc; wl_n++;
  end

  int aux_n = 0, done_cyc = 0;
  logic aux_is_poll;
  logic [7:0] aux_op_s; logic [23:0] aux_hi_s; logic [31:0] aux_lo_s;
  initial begin
    wait_done_i = 1'b0; poll_done_i = 1'b0;
    forever begin
      @(negedge clk_i);
      wait_done_i = 1'b0; poll_done_i = 1'b0;
      if (wait_start_o || poll_start_o) begin
        aux_n++; aux_is_poll = poll_start_o;
        aux_op_s = aux_op_o; aux_hi_s = aux_hi_o; aux_lo_s = aux_lo_o;
        repeat (AUX_LAT) @(negedge clk_i);
        if (aux_is_poll) poll_done_i = 1'b1; else wait_done_i = 1'b1;
        done_cyc = cyc;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    chk(1'b0, "watchdog", 64'(cyc), 64'd0);
    finish_run();
  end

  task automatic clr_mem();
    for (int i = 0; i < (1<<AW); i++) mem[i] = '0;
  endtask

  task automatic put(input int byte_addr, input logic [31:0] hi, input logic [31:0] lo);
    mem[byte_addr/4] = lo; mem[byte_addr/4 + 1] = hi;
  endtask

  function automatic logic [31:0] up(input logic [7:0] op, input logic [3:0] be, input logic [19:0] off);
    return {op, be, off};
  endfunction

  function automatic logic [63:0] call_ins(input int hb, input int tb);
    logic [51:0] pl;
    pl = {26'(hb >> 6), 26'(tb >> 6)};
    return {8'h0C, 4'h0, pl};
  endfunction

  task automatic run(input int h, input int t);
    int n;
    wl_n = 0;
    @(negedge clk_i);
    head_i = (AW+2)'(h); tail_i = (AW+2)'(t); start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    n = 0;
    while (busy_o && n < 5000) begin @(negedge clk_i); n++; end
    chk(n < 5000, "R2 run ends", 64'(n), 64'd0);
  endtask

  localparam logic [63:0] WR_VEC [0:5] = '{
    {8'h01, 4'hF, 20'h00010, 32'hDEADBEEF},
    {8'h01, 4'h1, 20'h00024, 32'h000000A5},
    {8'h01, 4'h8, 20'hFFFFC, 32'h5A000000},
    {8'h01, 4'h6, 20'h12340, 32'h00ABCD00},
    {8'h01, 4'h0, 20'h00000, 32'h11111111},
    {8'h01, 4'hA, 20'h80008, 32'hCAFEF00D}
  };

  initial begin
    clr_mem();
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(!busy_o, "R1 busy", 64'(busy_o), 0);
    chk(!reg_wr_o, "R1 reg_wr", 64'(reg_wr_o), 0);
    chk({irq_o, err_nest_o, err_op_o} == 3'b000, "R1 status", 64'({irq_o, err_nest_o, err_op_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R4 table of single writes
    foreach (WR_VEC[i]) begin
      clr_mem();
      put(0, WR_VEC[i][63:32], WR_VEC[i][31:0]);
      run(0, 64);
      chk(wl_n == 1, "R4 write count", 64'(wl_n), 1);
      chk(wl_addr[0] == WR_VEC[i][51:32] && wl_be[0] == WR_VEC[i][55:52] && wl_data[0] == WR_VEC[i][31:0],
          "R4 write fields", {wl_be[0], wl_addr[0], wl_data[0]}, {WR_VEC[i][55:32], WR_VEC[i][31:0]});
    end

    // R3 all no-ops
    clr_mem();
    run(0, 128);
    chk(wl_n == 0, "R3 nop writes", 64'(wl_n), 0);

    // R2 head equal tail: busy for one cycle
    @(negedge clk_i);
    head_i = 12'h080; tail_i = 12'h0BF; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    chk(busy_o == 1'b1, "R2 busy first cycle", 64'(busy_o), 1);
    @(negedge clk_i);
    chk(busy_o == 1'b0, "R2 busy dropped", 64'(busy_o), 0);

    // R5 indexed writes N=0, N=2, N=3 with non-zero pad
    clr_mem();
    put(0, up(8'h09, 4'h0, 20'h00100), 32'd0);
    put(8, up(8'h09, 4'h0, 20'h00200), 32'd2);
    mem[4] = 32'hA0; mem[5] = 32'hA1;
    put(24, up(8'h09, 4'h0, 20'h00300), 32'd3);
    mem[8] = 32'hB0; mem[9] = 32'hB1; mem[10] = 32'hB2; mem[11] = 32'hFFFFFFFF;
    put(48, up(8'h01, 4'hF, 20'h00400), 32'h0000ABCD);
    run(0, 64);
    chk(wl_n == 6, "R5 burst count", 64'(wl_n), 6);
    chk(wl_addr[0] == 20'h200 && wl_data[0] == 32'hA0 && wl_data[1] == 32'hA1 && wl_be[1] == 4'hF,
        "R5 even burst", {wl_addr[0], wl_data[1]}, {20'h200, 32'hA1});
    chk(wl_addr[4] == 20'h300 && wl_data[2] == 32'hB0 && wl_data[4] == 32'hB2,
        "R5 odd burst", {wl_addr[4], wl_data[4]}, {20'h300, 32'hB2});
    chk(wl_addr[5] == 20'h400 && wl_data[5] == 32'hABCD, "R5 pad skipped",
        {wl_addr[5], wl_data[5]}, {20'h400, 32'hABCD});

    // R6 wait then poll then write
    clr_mem();
    aux_n = 0;
    put(0, up(8'h03, 4'h5, 20'h60001), 32'h00001234);
    put(8, up(8'h0A, 4'h0, 20'h00ABC), 32'h0000F00F);
    put(16, up(8'h01, 4'hF, 20'h00044), 32'h77);
    run(0, 64);
    chk(aux_n == 2, "R6 aux count", 64'(aux_n), 2);
    chk(aux_op_s == 8'h0A && aux_is_poll && aux_hi_s == 24'h000ABC && aux_lo_s == 32'hF00F,
        "R6 poll operands", {aux_op_s, aux_hi_s, aux_lo_s}, {8'h0A, 24'h000ABC, 32'hF00F});
    chk(wl_n == 1 && wl_cyc[0] > done_cyc, "R6 stall until done", 64'(wl_cyc[0]), 64'(done_cyc + 1));
    clr_mem();
    put(0, up(8'h03, 4'h5, 20'h60001), 32'h00001234);
    run(0, 64);
    chk(aux_op_s == 8'h03 && !aux_is_poll && aux_hi_s == 24'h560001 && aux_lo_s == 32'h1234,
        "R6 wait operands", {aux_op_s, aux_hi_s, aux_lo_s}, {8'h03, 24'h560001, 32'h1234});

    // R7 interrupt sticky, write-1-clear
    clr_mem();
    put(0, up(8'h07, 4'h0, 20'h0), 32'h0);
    run(0, 64);
    chk(irq_o, "R7 irq set", 64'(irq_o), 1);
    repeat (3) @(negedge clk_i);
    chk(irq_o, "R7 irq held", 64'(irq_o), 1);
    clr_i = 3'b001; @(negedge clk_i); clr_i = 3'b000;
    chk(!irq_o, "R7 irq cleared", 64'(irq_o), 0);

    // R8 call and return
    clr_mem();
    put(0, call_ins(256, 320) >> 32, call_ins(256, 320));
    put(8, up(8'h01, 4'hF, 20'h00010), 32'h11);
    put(256, up(8'h01, 4'hF, 20'h00020), 32'h22);
    put(264, up(8'h09, 4'h0, 20'h00030), 32'd1);
    mem[68] = 32'h33;
    put(280, up(8'h01, 4'hF, 20'h00024), 32'h44);
    run(0, 64);
    chk(wl_n == 4, "R8 call count", 64'(wl_n), 4);
    chk(wl_data[0] == 32'h22 && wl_data[1] == 32'h33 && wl_data[2] == 32'h44 && wl_data[3] == 32'h11,
        "R8 call order", {wl_data[0], wl_data[3]}, {32'h22, 32'h11});
    chk(!err_nest_o, "R8 no nest error", 64'(err_nest_o), 0);

    // R9 nested call rejected
    clr_mem();
    put(0, call_ins(256, 320) >> 32, call_ins(256, 320));
    put(8, up(8'h01, 4'hF, 20'h00010), 32'h11);
    put(256, call_ins(512, 576) >> 32, call_ins(512, 576));
    put(264, up(8'h01, 4'hF, 20'h00020), 32'h22);
    put(512, up(8'h01, 4'hF, 20'h00030), 32'h99);
    run(0, 64);
    chk(wl_n == 2 && wl_data[0] == 32'h22 && wl_data[1] == 32'h11, "R9 nested skipped",
        {32'(wl_n), wl_data[0]}, {32'd2, 32'h22});
    chk(err_nest_o, "R9 error flag", 64'(err_nest_o), 1);
    clr_i = 3'b010; @(negedge clk_i); clr_i = 3'b000;
    chk(!err_nest_o, "R9 error cleared", 64'(err_nest_o), 0);

    // R10 unknown opcode stops execution
    clr_mem();
    put(0, up(8'h01, 4'hF, 20'h00050), 32'h55);
    put(8, up(8'h0F, 4'h0, 20'h0), 32'h0);
    put(16, up(8'h01, 4'hF, 20'h00054), 32'h66);
    run(0, 64);
    chk(wl_n == 1 && wl_data[0] == 32'h55, "R10 stop after bad op", 64'(wl_n), 1);
    chk(err_op_o, "R10 error flag", 64'(err_op_o), 1);
    clr_i = 3'b100; @(negedge clk_i); clr_i = 3'b000;
    chk(!err_op_o, "R10 error cleared", 64'(err_op_o), 0);

    // R11 halt at boundary
    clr_mem();
    put(0, up(8'h01, 4'hF, 20'h00060), 32'h77);
    halt_i = 1'b1;
    run(0, 64);
    halt_i = 1'b0;
    chk(wl_n == 0, "R11 halt no writes", 64'(wl_n), 0);
    chk(!busy_o, "R11 halt idle", 64'(busy_o), 0);

    finish_run();
  end
endmodule